// File: doc/BRIEF.md
# Page-Load Buffer Write Controller

This block sits between a host port and a behavioural nonvolatile array that is written one page at a time. The host presents byte loads as single-cycle strobes carrying an 18-bit address and an 8-bit value. The upper address bits name a page and the lower seven bits name a byte inside it. The bytes are gathered into a 128-byte staging buffer in whatever order they arrive. The page stays open as long as each new load follows the previous accepted one within a window of `WIN_CYC` clock cycles. When the window runs out, the controller starts a timed internal write that lasts `PROG_CYC` cycles and raises `busy` for that time. When the write ends, all 128 locations of the page are replaced together. Offsets that received no load are written as all ones, so their old contents are not kept.

A page cycle holds one page only. A load that names a different page while the page is open is dropped and reported by a one-cycle `page_err` pulse. Loads that arrive during the internal write are dropped with no report. The array is read through an asynchronous read port. Only `ARRAY_PAGES` pages are stored, selected by the low bits of the page number, so page numbers that differ only in their upper bits share storage. At reset every stored byte reads as all ones.

Top module: `page_load_writer`

## Requirements
- R1: After reset `busy` and `page_err` are low and every array location reads 8'hFF.
- R2: Address bits 6:0 select the byte offset and bits 17:7 select the page. A byte loaded at an address reads back at that same address once the write for its page has finished.
- R3: Loads within one page may come in any offset order, with gaps of 0 to `WIN_CYC`-1 idle cycles between them, and the final page contents do not depend on that order.
- R4: `busy` first reads high after exactly `WIN_CYC` clock edges, counted from the edge that sampled the last accepted load.
- R5: When a write finishes, every offset of the page that was not loaded in that page cycle reads 8'hFF, even if it held other data before.
- R6: `busy` stays high for exactly `PROG_CYC` cycles. While it is high, the array still shows the previous contents of the page. The new contents of all 128 offsets appear together when `busy` falls.
- R7: While a page is open, a load with a different page number is ignored and does not restart the window. `page_err` is high for exactly the one cycle that follows the edge sampling that load.
- R8: A load presented while `busy` is high has no effect on the array.
- R9: If one offset is loaded more than once in a page cycle, the last value loaded is the one written.
- R10: The array holds `ARRAY_PAGES` pages indexed by the low log2(`ARRAY_PAGES`) bits of the page number. With 16 pages, pages 3 and 19 share storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_valid | input | 1 | Byte-load strobe, one byte per cycle |
| load_addr | input | 18 | Load address: page in 17:7, offset in 6:0 |
| load_data | input | 8 | Byte to load |
| busy | output | 1 | High while the internal page write runs |
| page_err | output | 1 | One-cycle pulse for a load to a foreign page |
| rd_addr | input | 18 | Array read address |
| rd_data | output | 8 | Array read data, combinational from rd_addr |

## Verification
The bench builds the block with `WIN_CYC` = 6, `PROG_CYC` = 10 and `ARRAY_PAGES` = 16. With these values the window expiry, the exact write length and the point where the new page contents appear can be timed cycle by cycle over dozens of pages inside a short run. Sixteen stored pages let random page numbers across the full 11-bit page range collide in the array, which exercises the aliasing rule and the full overwrite of unloaded offsets with all ones. The six-cycle window is short enough for random gaps to span every legal spacing, including the last cycle before expiry.

// File: rtl/plb_pkg.sv
package plb_pkg;

   typedef enum logic [1:0] {
      PLB_IDLE = 2'd0,
      PLB_LOAD = 2'd1,
      PLB_PROG = 2'd2
   } plb_state_e;

   function automatic int plb_cnt_width(input int a, input int b);
      int top;
      top = (a > b) ? a : b;
      return (top < 2) ? 1 : $clog2(top);
   endfunction

endpackage

// File: rtl/plb_timer.sv
module plb_timer #(
   parameter int WIN_CYC  = 200,
   parameter int PROG_CYC = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm_win,
   input  logic arm_prog,
   output logic expired
);
   import plb_pkg::*;

   localparam int CW = plb_cnt_width(WIN_CYC, PROG_CYC);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (arm_win) begin
         cnt_q <= CW'(WIN_CYC - 1);
      end else if (arm_prog) begin
         cnt_q <= CW'(PROG_CYC - 1);
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/plb_page_buf.sv
module plb_page_buf #(
   parameter int OFF_W  = 7,
   parameter int DATA_W = 8
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                wr_en,
   input  logic [OFF_W-1:0]                    wr_off,
   input  logic [DATA_W-1:0]                   wr_data,
   input  logic                                clr,
   output logic [(DATA_W << OFF_W)-1:0]        page_img
);
   localparam int PAGE_BYTES = 1 << OFF_W;

   for (genvar b = 0; b < PAGE_BYTES; b++) begin : g_slot
      logic [DATA_W-1:0] val_q;
      logic              full_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            full_q <= 1'b0;
            val_q  <= '1;
         end else if (clr) begin
            full_q <= 1'b0;
         end else if (wr_en && (wr_off == OFF_W'(b))) begin
            full_q <= 1'b1;
            val_q  <= wr_data;
         end
      end

      assign page_img[b*DATA_W +: DATA_W] = full_q ? val_q : {DATA_W{1'b1}};
   end

endmodule

// File: rtl/plb_array.sv
module plb_array #(
   parameter int OFF_W       = 7,
   parameter int DATA_W      = 8,
   parameter int PAGE_W      = 11,
   parameter int ARRAY_PAGES = 16
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         commit,
   input  logic [PAGE_W-1:0]            commit_page,
   input  logic [(DATA_W << OFF_W)-1:0] commit_img,
   input  logic [PAGE_W-1:0]            rd_page,
   input  logic [OFF_W-1:0]             rd_off,
   output logic [DATA_W-1:0]            rd_data
);
   localparam int IMG_W = DATA_W << OFF_W;
   localparam int IDX_W = (ARRAY_PAGES > 1) ? $clog2(ARRAY_PAGES) : 1;

   logic [IDX_W-1:0] wr_idx, rd_idx;
   logic [IMG_W-1:0] mem_q [ARRAY_PAGES];

   if (ARRAY_PAGES == 1) begin : g_single
      assign wr_idx = '0;
      assign rd_idx = '0;
   end else begin : g_multi
      assign wr_idx = commit_page[IDX_W-1:0];
      assign rd_idx = rd_page[IDX_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int p = 0; p < ARRAY_PAGES; p++) mem_q[p] <= '1;
      end else if (commit) begin
         mem_q[wr_idx] <= commit_img;
      end
   end

   assign rd_data = mem_q[rd_idx][rd_off*DATA_W +: DATA_W];

endmodule

// File: rtl/page_load_writer.sv
module page_load_writer #(
   parameter int ADDR_W      = 18,
   parameter int OFF_W       = 7,
   parameter int DATA_W      = 8,
   parameter int WIN_CYC     = 25000,
   parameter int PROG_CYC    = 125000,
   parameter int ARRAY_PAGES = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_valid,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic [DATA_W-1:0] load_data,
   output logic              busy,
   output logic              page_err,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   import plb_pkg::*;

   localparam int PAGE_W = ADDR_W - OFF_W;
   localparam int IMG_W  = DATA_W << OFF_W;

   if (OFF_W < 1 || ADDR_W <= OFF_W) begin : g_bad_split
      $error("page_load_writer: address split is invalid");
   end
   if (WIN_CYC < 1 || PROG_CYC < 1) begin : g_bad_time
      $error("page_load_writer: window and write lengths must be at least 1");
   end
   if (ARRAY_PAGES < 1 || (ARRAY_PAGES & (ARRAY_PAGES - 1)) != 0) begin : g_bad_depth
      $error("page_load_writer: ARRAY_PAGES must be a power of two");
   end
   if (PAGE_W < 31 && ARRAY_PAGES > (1 << PAGE_W)) begin : g_bad_fit
      $error("page_load_writer: more array pages than page numbers");
   end

   plb_state_e        state_q, state_d;
   logic [PAGE_W-1:0] page_q, ld_page;
   logic              same_page, accept, mismatch;
   logic              arm_prog, commit, expired, err_q;
   logic [IMG_W-1:0]  page_img;

   assign ld_page   = load_addr[ADDR_W-1:OFF_W];
   assign same_page = (ld_page == page_q);
   assign accept    = load_valid &&
                      ((state_q == PLB_IDLE) || (state_q == PLB_LOAD && same_page));
   assign mismatch  = load_valid && (state_q == PLB_LOAD) && !same_page;

   always_comb begin
      state_d  = state_q;
      arm_prog = 1'b0;
      commit   = 1'b0;
      unique case (state_q)
         PLB_IDLE: if (accept) state_d = PLB_LOAD;
         PLB_LOAD: if (!accept && expired) begin
            state_d  = PLB_PROG;
            arm_prog = 1'b1;
         end
         PLB_PROG: if (expired) begin
            state_d = PLB_IDLE;
            commit  = 1'b1;
         end
         default: state_d = PLB_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= PLB_IDLE;
         page_q  <= '0;
         err_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         err_q   <= mismatch;
         if (accept && state_q == PLB_IDLE) page_q <= ld_page;
      end
   end

   plb_timer #(
      .WIN_CYC (WIN_CYC),
      .PROG_CYC(PROG_CYC)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .arm_win (accept),
      .arm_prog(arm_prog),
      .expired (expired)
   );

   plb_page_buf #(
      .OFF_W (OFF_W),
      .DATA_W(DATA_W)
   ) u_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (accept),
      .wr_off  (load_addr[OFF_W-1:0]),
      .wr_data (load_data),
      .clr     (commit),
      .page_img(page_img)
   );

   plb_array #(
      .OFF_W      (OFF_W),
      .DATA_W     (DATA_W),
      .PAGE_W     (PAGE_W),
      .ARRAY_PAGES(ARRAY_PAGES)
   ) u_array (
      .clk        (clk),
      .rst_n      (rst_n),
      .commit     (commit),
      .commit_page(page_q),
      .commit_img (page_img),
      .rd_page    (rd_addr[ADDR_W-1:OFF_W]),
      .rd_off     (rd_addr[OFF_W-1:0]),
      .rd_data    (rd_data)
   );

   assign busy     = (state_q == PLB_PROG);
   assign page_err = err_q;

endmodule

// File: rtl/plb_checker.sv
module plb_checker #(
   parameter int ADDR_W   = 18,
   parameter int OFF_W    = 7,
   parameter int WIN_CYC  = 25000,
   parameter int PROG_CYC = 125000
) (
   input logic              clk,
   input logic              rst_n,
   input logic              load_valid,
   input logic [ADDR_W-1:0] load_addr,
   input logic              busy,
   input logic              page_err
);
   localparam int PAGE_W = ADDR_W - OFF_W;
   localparam int QW     = $clog2(WIN_CYC + 2);
   localparam int RW     = $clog2(PROG_CYC + 2);

   logic              open_q;
   logic [PAGE_W-1:0] pg_q;
   logic [QW-1:0]     quiet_q;
   logic [RW-1:0]     run_q;
   logic              took, foreign;

   assign took    = load_valid && !busy &&
                    (!open_q || load_addr[ADDR_W-1:OFF_W] == pg_q);
   assign foreign = load_valid && !busy && open_q &&
                    (load_addr[ADDR_W-1:OFF_W] != pg_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_q  <= 1'b0;
         pg_q    <= '0;
         quiet_q <= '0;
         run_q   <= '0;
      end else begin
         if (busy) begin
            open_q <= 1'b0;
         end else if (took && !open_q) begin
            open_q <= 1'b1;
            pg_q   <= load_addr[ADDR_W-1:OFF_W];
         end
         if (took) quiet_q <= '0;
         else if (quiet_q != {QW{1'b1}}) quiet_q <= quiet_q + 1'b1;
         if (!busy) run_q <= '0;
         else if (run_q != {RW{1'b1}}) run_q <= run_q + 1'b1;
      end
   end

   assert_busy_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (int'(quiet_q) == WIN_CYC));

   assert_busy_length_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (int'(run_q) == PROG_CYC));

   assert_busy_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (int'(run_q) < PROG_CYC));

   assert_err_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      page_err |-> $past(foreign));

   assert_err_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      foreign |=> page_err);

endmodule

bind page_load_writer plb_checker #(
   .ADDR_W  (ADDR_W),
   .OFF_W   (OFF_W),
   .WIN_CYC (WIN_CYC),
   .PROG_CYC(PROG_CYC)
) u_plb_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .load_valid(load_valid),
   .load_addr (load_addr),
   .busy      (busy),
   .page_err  (page_err)
);

// File: tb/page_load_writer_bench.sv
`timescale 1ns/1ps
module page_load_writer_bench;
   localparam int AW = 18;
   localparam int OW = 7;
   localparam int DW = 8;
   localparam int W  = 6;
   localparam int P  = 10;
   localparam int NP = 16;
   localparam int PB = 128;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          load_valid = 1'b0;
   logic [AW-1:0] load_addr = '0;
   logic [DW-1:0] load_data = '0;
   logic          busy, page_err;
   logic [AW-1:0] rd_addr = '0;
   logic [DW-1:0] rd_data;

   int n_run = 0;
   int n_fail = 0;

   logic [7:0] exp_mem [NP*PB];
   logic [7:0] buf_d [PB];
   bit         buf_v [PB];
   int         cur_page;
   int         first_off;

   always #4 clk = ~clk;

   page_load_writer #(
      .ADDR_W(AW), .OFF_W(OW), .DATA_W(DW),
      .WIN_CYC(W), .PROG_CYC(P), .ARRAY_PAGES(NP)
   ) u_page_load_writer (
      .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .load_addr(load_addr),
      .load_data(load_data), .busy(busy), .page_err(page_err),
      .rd_addr(rd_addr), .rd_data(rd_data)
   );

   function automatic logic [AW-1:0] mk_addr(input int page, input int off);
      return AW'(page * PB + off);
   endfunction

   function automatic int slot(input int page, input int off);
      return (page % NP) * PB + off;
   endfunction

   function automatic logic [7:0] staged(input int off);
      return buf_v[off] ? buf_d[off] : 8'hFF;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int expv);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
      end
   endtask

   task automatic peek(input int page, input int off, output logic [7:0] v);
      rd_addr = mk_addr(page, off);
      #1;
      v = rd_data;
   endtask

   task automatic begin_page(input int page);
      cur_page  = page;
      first_off = -1;
      for (int i = 0; i < PB; i++) buf_v[i] = 1'b0;
   endtask

   task automatic drive_load(input int page, input int off, input logic [7:0] val);
      load_valid = 1'b1;
      load_addr  = mk_addr(page, off);
      load_data  = val;
      @(negedge clk);
      load_valid = 1'b0;
   endtask

   task automatic put(input int off, input logic [7:0] val);
      drive_load(cur_page, off, val);
      buf_d[off] = val;
      buf_v[off] = 1'b1;
      if (first_off < 0) first_off = off;
   endtask

   task automatic finish_page(input int already, input bit inject);
      int         cnt;
      int         nb;
      int         mism;
      int         bad_off;
      int         inj_off;
      logic [7:0] inj_val, v, bad_v;
      cnt = already;
      do begin
         @(negedge clk);
         cnt++;
      end while (!busy && cnt < W + 20);
      check(cnt == W, "R4 busy start delay", cnt, W);
      peek(cur_page, first_off, v);
      check(v == exp_mem[slot(cur_page, first_off)], "R6 old data while busy",
            v, exp_mem[slot(cur_page, first_off)]);
      inj_off = int'($urandom % PB);
      inj_val = ~staged(inj_off);
      nb = 1;
      for (int k = 0; k < P + 20; k++) begin
         if (inject && k == 0) begin
            load_valid = 1'b1;
            load_addr  = mk_addr(cur_page, inj_off);
            load_data  = inj_val;
         end
         @(negedge clk);
         load_valid = 1'b0;
         if (busy) nb++;
         else break;
      end
      check(nb == P, "R6 busy length", nb, P);
      for (int i = 0; i < PB; i++) exp_mem[slot(cur_page, i)] = staged(i);
      mism = 0;
      bad_off = 0;
      bad_v = 8'h00;
      for (int i = 0; i < PB; i++) begin
         peek(cur_page, i, v);
         if (v != exp_mem[slot(cur_page, i)]) begin
            if (mism == 0) begin
               bad_off = i;
               bad_v   = v;
            end
            mism++;
         end
      end
      check(mism == 0, "R2 R3 R5 R9 page contents", bad_v, exp_mem[slot(cur_page, bad_off)]);
      if (inject) begin
         peek(cur_page, inj_off, v);
         check(v == exp_mem[slot(cur_page, inj_off)], "R8 load during busy ignored",
               v, exp_mem[slot(cur_page, inj_off)]);
      end
      @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [7:0] v;
      void'($urandom(32'h00C0FFEE));
      for (int i = 0; i < NP * PB; i++) exp_mem[i] = 8'hFF;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check(busy == 1'b0, "R1 busy after reset", busy, 0);
      check(page_err == 1'b0, "R1 page_err after reset", page_err, 0);
      peek(0, 0, v);   check(v == 8'hFF, "R1 erased read", v, 8'hFF);
      peek(2047, 127, v); check(v == 8'hFF, "R1 erased read", v, 8'hFF);
      @(negedge clk);

      // R3 R9: out-of-order loads and a repeated offset
      begin_page(5);
      put(10, 8'h11);
      put(127, 8'h7F);
      @(negedge clk);
      put(0, 8'h01);
      repeat (W - 1) @(negedge clk);
      put(10, 8'h3C);
      finish_page(0, 1'b0);
      peek(5, 10, v); check(v == 8'h3C, "R9 last value wins", v, 8'h3C);
      peek(5, 127, v); check(v == 8'h7F, "R3 reverse order byte", v, 8'h7F);

      // R5: full page then a single-byte rewrite
      begin_page(7);
      for (int i = 0; i < PB; i++) put(i, 8'(i ^ 8'h5A));
      finish_page(0, 1'b0);
      begin_page(7);
      put(40, 8'hC3);
      finish_page(0, 1'b0);
      peek(7, 41, v); check(v == 8'hFF, "R5 unloaded offset erased", v, 8'hFF);
      peek(7, 40, v); check(v == 8'hC3, "R2 loaded offset kept", v, 8'hC3);

      // R7: foreign page load ignored, window not restarted
      begin_page(9);
      put(1, 8'h99);
      drive_load(10, 2, 8'h12);
      check(page_err == 1'b1, "R7 page_err pulse", page_err, 1);
      @(negedge clk);
      check(page_err == 1'b0, "R7 page_err single cycle", page_err, 0);
      finish_page(2, 1'b0);
      peek(10, 2, v); check(v == 8'hFF, "R7 foreign byte dropped", v, 8'hFF);
      peek(9, 2, v); check(v == 8'hFF, "R7 foreign byte not in open page", v, 8'hFF);

      // R10: page 19 aliases page 3 with 16 stored pages
      begin_page(19);
      put(5, 8'hA5);
      finish_page(0, 1'b1);
      peek(3, 5, v); check(v == 8'hA5, "R10 page alias", v, 8'hA5);
      @(negedge clk);

      // R2 R3 R8 R9: random pages
      for (int pg = 0; pg < 30; pg++) begin
         int nl;
         begin_page(int'($urandom % 2048));
         nl = 1 + int'($urandom % 24);
         for (int i = 0; i < nl; i++) begin
            int off;
            off = (i > 0 && ($urandom % 5) == 0) ? first_off : int'($urandom % PB);
            put(off, 8'($urandom));
            if (i < nl - 1) repeat (int'($urandom % W)) @(negedge clk);
         end
         finish_page(0, ($urandom % 2) == 0);
      end

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule